// File: doc/BRIEF.md
# Packed Instruction Expansion Sequencer

This block sits at the front of instruction decode. Every fetched 32-bit word goes through it. Most words are ordinary instructions and pass straight through. Some words carry a packed opcode instead. A packed word holds up to five 5-bit references into a small instruction register file. The block expands such a word into the referenced instructions and issues them one per cycle, in slot order. While it drains the word, it raises a fetch-stall output so that fetch holds the next word.

Each register-file entry holds the fixed upper half of an instruction and a 16-bit default immediate. There are four windows (banks) of 32 entries each. A window-select input picks the active bank. Entry 0 of every window is a permanent nop.

A packed word can give up one or two of its slots to parameters:
- For an ordinary instruction, a parameter is an index into a 32-entry immediate table, and the value read there replaces the instruction's immediate.
- For a branch, the parameter together with the word's sign bit forms the displacement directly.

A flush input abandons whatever is left of the current word.

Top module: `pack_expand_seq`

## Requirements
- R1: A word whose bits [31:26] are not one of 0x38..0x3D passes through unchanged. It appears on issue_instr_o with issue_valid_o high in the cycle after it is accepted, and stall_o stays low.
- R2: Packed field positions are: kind [31:26], slots A [25:21], B [20:16], C [15:11], D [10:6], sign bit [5], E [4:0]. The kinds are:
  - 0x38 issues A,B,C,D,E.
  - 0x39 issues A,B,C,D.
  - 0x3A issues A,B,C,D, with E as parameter for D.
  - 0x3B issues A,B,C.
  - 0x3C issues A,B,C, with D as parameter for A and E as parameter for C.
  - 0x3D issues A,B, with D as parameter for A and E as parameter for B.
- R3: Slots issue one per cycle in the order A, B, C, D, E. The first slot appears in the cycle after acceptance.
- R4: Index-0 slots after the last non-zero slot are skipped, and a packed word whose slots are all zero issues nothing. Index-0 slots before the last non-zero slot issue 32'h0. stall_o is high from acceptance until the cycle in which the last issued slot appears.
- R5: Entry 0 of every window reads as nop (32'h0), and writes to it are ignored.
- R6: A slot with no parameter issues {stored upper half, stored default immediate}.
- R7: A parameter on a non-branch slot replaces the immediate with the immediate-table entry that it indexes.
- R8: An entry whose bits [31:26] equal 0x04 is a branch. A parameter on a branch slot gives the immediate as {sign bit, parameter} sign-extended to 16 bits.
- R9: The window is sampled when the packed word is accepted and holds for all of that word's slots.
- R10: A flush empties the block. In the next cycle issue_valid_o and stall_o are low.
- R11: A word held on the fetch inputs while stall_o is high is not consumed. It is accepted in the cycle stall_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_valid_i | input | 1 | Fetched word present |
| fetch_word_i | input | 32 | Fetched word |
| win_i | input | 2 | Active register-file window |
| flush_i | input | 1 | Abandon remaining slots |
| stall_o | output | 1 | Hold fetch |
| issue_valid_o | output | 1 | Issued instruction valid |
| issue_instr_o | output | 32 | Issued instruction |
| irf_we_i | input | 1 | Register-file entry write |
| irf_win_i | input | 2 | Write window |
| irf_idx_i | input | 5 | Write entry index |
| irf_op_i | input | 16 | Upper instruction half to store |
| irf_dimm_i | input | 16 | Default immediate to store |
| imm_we_i | input | 1 | Immediate-table write |
| imm_idx_i | input | 5 | Immediate-table index |
| imm_val_i | input | 16 | Immediate value |

## Verification
Every result is due a fixed number of register stages after its stimulus:
- An unpacked word, or the first slot of a packed word, shows one clock after the edge that accepts it.
- Slot k shows k clocks after that edge.
- A flush clears the outputs one clock after its edge.

The bench drives inputs on falling edges and samples outputs on the next falling edge, checking one expected slot per cycle. That spacing makes every comparison land exactly in the cycle of its register stage. Stall is compared in the same samples, so a skipped trailing slot or an extra cycle of stall shows up as a mismatch at a known cycle.

// File: rtl/pes_pkg.sv
package pes_pkg;
  localparam int unsigned SLOTS  = 5;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned DEPTH  = 1 << IDX_W;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 2 * HALF_W;
  localparam int unsigned CNT_W  = 3;

  localparam logic [5:0] K_T5 = 6'h38;
  localparam logic [5:0] K_T4 = 6'h39;
  localparam logic [5:0] K_P4 = 6'h3A;
  localparam logic [5:0] K_T3 = 6'h3B;
  localparam logic [5:0] K_P3 = 6'h3C;
  localparam logic [5:0] K_P2 = 6'h3D;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             has_p;
    logic [IDX_W-1:0] par;
  } slot_t;
endpackage

// File: rtl/pes_irf.sv
module pes_irf
  import pes_pkg::*;
#(
  parameter int unsigned WINDOWS = 4,
  localparam int unsigned WIN_W  = (WINDOWS > 1) ? $clog2(WINDOWS) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [WIN_W-1:0]  wwin_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [HALF_W-1:0] wop_i,
  input  logic [HALF_W-1:0] wdimm_i,
  input  logic [WIN_W-1:0]  rwin_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [HALF_W-1:0] rop_o,
  output logic [HALF_W-1:0] rdimm_o
);
  logic [HALF_W-1:0] op_w   [WINDOWS];
  logic [HALF_W-1:0] dimm_w [WINDOWS];

  for (genvar w = 0; w < WINDOWS; w++) begin : g_win
    logic [HALF_W-1:0] op_q   [DEPTH];
    logic [HALF_W-1:0] dimm_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && wwin_i == WIN_W'(w) && widx_i != '0) begin
        op_q[widx_i]   <= wop_i;
        dimm_q[widx_i] <= wdimm_i;
      end
    end
    assign op_w[w]   = op_q[ridx_i];
    assign dimm_w[w] = dimm_q[ridx_i];
  end

  // entry 0 is a hard nop
  assign rop_o   = (ridx_i == '0) ? '0 : op_w[rwin_i];
  assign rdimm_o = (ridx_i == '0) ? '0 : dimm_w[rwin_i];
endmodule

// File: rtl/pes_imm_tab.sv
module pes_imm_tab
  import pes_pkg::*;
(
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [HALF_W-1:0] wval_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [HALF_W-1:0] rval_o
);
  logic [HALF_W-1:0] tab_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) tab_q[widx_i] <= wval_i;
  end

  assign rval_o = tab_q[ridx_i];
endmodule

// File: rtl/pes_decode.sv
module pes_decode
  import pes_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic              packed_o,
  output slot_t             slots_o [SLOTS],
  output logic [CNT_W-1:0]  cnt_o
);
  logic [IDX_W-1:0] fld [SLOTS];
  logic [CNT_W-1:0] n;
  logic [CNT_W-1:0] tgt_d, tgt_e;  // slot number fed by field D / E, 0 = none

  assign fld[0] = word_i[25:21];
  assign fld[1] = word_i[20:16];
  assign fld[2] = word_i[15:11];
  assign fld[3] = word_i[10:6];
  assign fld[4] = word_i[4:0];

  always_comb begin
    packed_o = 1'b1;
    n        = '0;
    tgt_d    = '0;
    tgt_e    = '0;
    unique case (word_i[31:26])
      K_T5: n = 3'd5;
      K_T4: n = 3'd4;
      K_P4: begin n = 3'd4; tgt_e = 3'd4; end
      K_T3: n = 3'd3;
      K_P3: begin n = 3'd3; tgt_d = 3'd1; tgt_e = 3'd3; end
      K_P2: begin n = 3'd2; tgt_d = 3'd1; tgt_e = 3'd2; end
      default: packed_o = 1'b0;
    endcase
  end

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < SLOTS; i++) begin
      slots_o[i].idx   = (CNT_W'(i) < n) ? fld[i] : '0;
      slots_o[i].has_p = (tgt_d == CNT_W'(i + 1)) || (tgt_e == CNT_W'(i + 1));
      slots_o[i].par   = (tgt_e == CNT_W'(i + 1)) ? fld[4] : fld[3];
      if (slots_o[i].idx != '0) cnt_o = CNT_W'(i + 1);  // trim trailing nops
    end
  end
endmodule

// File: rtl/pack_expand_seq.sv
module pack_expand_seq
  import pes_pkg::*;
#(
  parameter int unsigned WINDOWS = 4,
  parameter logic [5:0]  BR_OP   = 6'h04,
  localparam int unsigned WIN_W  = (WINDOWS > 1) ? $clog2(WINDOWS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [WORD_W-1:0] fetch_word_i,
  input  logic [WIN_W-1:0]  win_i,
  input  logic              flush_i,
  output logic              stall_o,
  output logic              issue_valid_o,
  output logic [WORD_W-1:0] issue_instr_o,
  input  logic              irf_we_i,
  input  logic [WIN_W-1:0]  irf_win_i,
  input  logic [IDX_W-1:0]  irf_idx_i,
  input  logic [HALF_W-1:0] irf_op_i,
  input  logic [HALF_W-1:0] irf_dimm_i,
  input  logic              imm_we_i,
  input  logic [IDX_W-1:0]  imm_idx_i,
  input  logic [HALF_W-1:0] imm_val_i
);
  localparam int unsigned EXT_W = HALF_W - IDX_W - 1;

  logic             dec_pk;
  slot_t            dec_slots [SLOTS];
  logic [CNT_W-1:0] dec_cnt;

  slot_t            slots_q [SLOTS];
  logic [CNT_W-1:0] ptr_q, rem_q;
  logic [WIN_W-1:0] win_q;
  logic             s_q;

  logic              busy, acc;
  slot_t             cur;
  logic [WIN_W-1:0]  cur_win;
  logic              cur_s;
  logic [HALF_W-1:0] r_op, r_dimm, r_imm, imm_sel;
  logic [WORD_W-1:0] slot_word;

  pes_decode i_dec (
    .word_i   (fetch_word_i),
    .packed_o (dec_pk),
    .slots_o  (dec_slots),
    .cnt_o    (dec_cnt)
  );

  assign busy    = (rem_q != '0);
  assign stall_o = busy;
  assign acc     = fetch_valid_i && !busy && !flush_i;

  // first slot is looked up in the accept cycle, the rest from latched state
  always_comb begin
    cur     = busy ? slots_q[ptr_q] : dec_slots[0];
    cur_win = busy ? win_q : win_i;
    cur_s   = busy ? s_q : fetch_word_i[5];
  end

  pes_irf #(.WINDOWS(WINDOWS)) i_irf (
    .clk_i   (clk_i),
    .we_i    (irf_we_i),
    .wwin_i  (irf_win_i),
    .widx_i  (irf_idx_i),
    .wop_i   (irf_op_i),
    .wdimm_i (irf_dimm_i),
    .rwin_i  (cur_win),
    .ridx_i  (cur.idx),
    .rop_o   (r_op),
    .rdimm_o (r_dimm)
  );

  pes_imm_tab i_imm (
    .clk_i  (clk_i),
    .we_i   (imm_we_i),
    .widx_i (imm_idx_i),
    .wval_i (imm_val_i),
    .ridx_i (cur.par),
    .rval_o (r_imm)
  );

  always_comb begin
    if (!cur.has_p)                          imm_sel = r_dimm;
    else if (r_op[HALF_W-1 -: 6] == BR_OP)   imm_sel = {{EXT_W{cur_s}}, cur_s, cur.par};
    else                                     imm_sel = r_imm;
    slot_word = (cur.idx == '0) ? '0 : {r_op, imm_sel};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_valid_o <= 1'b0;
      issue_instr_o <= '0;
      ptr_q         <= '0;
      rem_q         <= '0;
      win_q         <= '0;
      s_q           <= 1'b0;
      for (int i = 0; i < SLOTS; i++) slots_q[i] <= '0;
    end else if (flush_i) begin
      issue_valid_o <= 1'b0;
      rem_q         <= '0;
    end else if (busy) begin
      issue_valid_o <= 1'b1;
      issue_instr_o <= slot_word;
      ptr_q         <= ptr_q + 1'b1;
      rem_q         <= rem_q - 1'b1;
    end else if (fetch_valid_i) begin
      if (!dec_pk) begin
        issue_valid_o <= 1'b1;
        issue_instr_o <= fetch_word_i;
      end else if (dec_cnt != '0) begin
        issue_valid_o <= 1'b1;
        issue_instr_o <= slot_word;
        slots_q       <= dec_slots;
        ptr_q         <= CNT_W'(1);
        rem_q         <= dec_cnt - 1'b1;
        win_q         <= win_i;
        s_q           <= fetch_word_i[5];
      end else begin
        issue_valid_o <= 1'b0;
      end
    end else begin
      issue_valid_o <= 1'b0;
    end
  end

  p_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !dec_pk) |=> (issue_valid_o && !stall_o && issue_instr_o == $past(fetch_word_i)));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !flush_i) |=> (issue_valid_o && rem_q == $past(rem_q) - 1'b1));

  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && !fetch_valid_i) |=> !issue_valid_o);

  p_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!issue_valid_o && !stall_o));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && fetch_valid_i && !flush_i) |=> $stable(win_q));
endmodule

// File: tb/test_pack_expand_seq.sv
`timescale 1ns/1ps
module test_pack_expand_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fv = 1'b0;
  logic [31:0] fw = '0;
  logic [1:0]  win = '0;
  logic        flush = 1'b0;
  logic        stall, iv;
  logic [31:0] ins;
  logic        irf_we = 1'b0;
  logic [1:0]  irf_win = '0;
  logic [4:0]  irf_idx = '0;
  logic [15:0] irf_op = '0, irf_dimm = '0;
  logic        imm_we = 1'b0;
  logic [4:0]  imm_idx = '0;
  logic [15:0] imm_val = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_op [4][32];
  logic [15:0] m_dm [4][32];
  logic [15:0] m_im [32];

  always #2.5 clk = ~clk;

  pack_expand_seq i_pack_expand_seq (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(fv), .fetch_word_i(fw),
    .win_i(win), .flush_i(flush), .stall_o(stall), .issue_valid_o(iv),
    .issue_instr_o(ins), .irf_we_i(irf_we), .irf_win_i(irf_win),
    .irf_idx_i(irf_idx), .irf_op_i(irf_op), .irf_dimm_i(irf_dimm),
    .imm_we_i(imm_we), .imm_idx_i(imm_idx), .imm_val_i(imm_val));

  // expected slot output from requirements R5-R8
  function automatic logic [31:0] xp(int w, int idx, bit hp, logic [4:0] par, bit s);
    logic [15:0] imm;
    if (idx == 0) return 32'h0;
    if (!hp) imm = m_dm[w][idx];
    else if (m_op[w][idx][15:10] == 6'h04) imm = {{10{s}}, s, par};
    else imm = m_im[par];
    return {m_op[w][idx], imm};
  endfunction

  function automatic logic [31:0] pk(logic [5:0] k, logic [4:0] a, logic [4:0] b,
                                     logic [4:0] c, logic [4:0] d, bit s, logic [4:0] e);
    return {k, a, b, c, d, s, e};
  endfunction

  task automatic chk(string req, bit ev, logic [31:0] ei, bit es);
    checks++;
    if (iv !== ev || stall !== es || (ev && ins !== ei)) begin
      errors++;
      $display("FAIL %s: valid=%0b instr=%h stall=%0b expected valid=%0b instr=%h stall=%0b",
               req, iv, ins, stall, ev, ei, es);
    end
  endtask

  task automatic wr_irf(int w, int i, logic [15:0] op, logic [15:0] dm);
    @(negedge clk);
    irf_we = 1; irf_win = 2'(w); irf_idx = 5'(i); irf_op = op; irf_dimm = dm;
    @(negedge clk);
    irf_we = 0;
    if (i != 0) begin m_op[w][i] = op; m_dm[w][i] = dm; end
  endtask

  task automatic wr_imm(int i, logic [15:0] v);
    @(negedge clk);
    imm_we = 1; imm_idx = 5'(i); imm_val = v;
    @(negedge clk);
    imm_we = 0; m_im[i] = v;
  endtask

  task automatic send(logic [31:0] w);
    @(negedge clk);
    fv = 1; fw = w;
    @(negedge clk);
    fv = 0;
  endtask

  task automatic t_reset;
    chk("R10 reset state", 0, 0, 0);
  endtask

  task automatic t_pass;
    send(32'h8FA3_0008);
    chk("R1 passthrough", 1, 32'h8FA3_0008, 0);
    send(32'hFC00_1234);
    chk("R1 kind 0x3F passthrough", 1, 32'hFC00_1234, 0);
    @(negedge clk);
    chk("R4 idle no issue", 0, 0, 0);
  endtask

  task automatic t_five;
    send(pk(6'h38, 1, 2, 3, 4, 0, 5));
    chk("R3 R6 slot A", 1, xp(0, 1, 0, 0, 0), 1);
    @(negedge clk); chk("R3 R6 slot B branch default", 1, xp(0, 2, 0, 0, 0), 1);
    @(negedge clk); chk("R3 slot C", 1, xp(0, 3, 0, 0, 0), 1);
    @(negedge clk); chk("R3 slot D", 1, xp(0, 4, 0, 0, 0), 1);
    @(negedge clk); chk("R3 R4 slot E last", 1, xp(0, 5, 0, 0, 0), 0);
    @(negedge clk); chk("R4 drained", 0, 0, 0);
  endtask

  task automatic t_trim;
    send(pk(6'h3B, 4, 0, 1, 7, 0, 7));
    chk("R2 R4 three: A", 1, xp(0, 4, 0, 0, 0), 1);
    @(negedge clk); chk("R4 inner nop", 1, 32'h0, 1);
    @(negedge clk); chk("R4 slot C last", 1, xp(0, 1, 0, 0, 0), 0);
    send(pk(6'h39, 1, 3, 0, 0, 0, 5));
    chk("R4 four trimmed A", 1, xp(0, 1, 0, 0, 0), 1);
    @(negedge clk); chk("R4 four trimmed B last", 1, xp(0, 3, 0, 0, 0), 0);
    @(negedge clk); chk("R2 R4 field E not issued by 0x39", 0, 0, 0);
    send(pk(6'h38, 0, 0, 0, 0, 0, 0));
    chk("R4 all-zero word issues nothing", 0, 0, 0);
  endtask

  task automatic t_params;
    send(pk(6'h3C, 1, 3, 2, 3, 1, 5'b11011));
    chk("R7 P3 slot A table imm", 1, xp(0, 1, 1, 3, 1), 1);
    checks++;
    if (ins[15:0] !== 16'h0020) begin
      errors++; $display("FAIL R7: imm=%h expected 0020", ins[15:0]);
    end
    @(negedge clk); chk("R2 P3 slot B default", 1, xp(0, 3, 0, 0, 0), 1);
    @(negedge clk); chk("R8 P3 branch neg disp", 1, xp(0, 2, 1, 5'b11011, 1), 0);
    checks++;
    if (ins[15:0] !== 16'hFFFB) begin
      errors++; $display("FAIL R8: disp=%h expected fffb", ins[15:0]);
    end
    send(pk(6'h3D, 5, 2, 0, 9, 0, 3));
    chk("R7 P2 slot A table imm", 1, xp(0, 5, 1, 9, 0), 1);
    @(negedge clk); chk("R8 P2 branch pos disp", 1, xp(0, 2, 1, 3, 0), 0);
    send(pk(6'h3A, 1, 3, 4, 2, 0, 7));
    chk("R2 P4 slot A", 1, xp(0, 1, 0, 0, 0), 1);
    @(negedge clk); chk("R2 P4 slot B", 1, xp(0, 3, 0, 0, 0), 1);
    @(negedge clk); chk("R2 P4 slot C", 1, xp(0, 4, 0, 0, 0), 1);
    @(negedge clk); chk("R8 P4 slot D branch", 1, xp(0, 2, 1, 7, 0), 0);
  endtask

  task automatic t_window;
    win = 2'd1;
    send(pk(6'h39, 1, 0, 0, 1, 0, 0));
    win = 2'd0;
    chk("R9 window 1 slot A", 1, xp(1, 1, 0, 0, 0), 1);
    @(negedge clk); chk("R9 nop", 1, 0, 1);
    @(negedge clk); chk("R9 nop", 1, 0, 1);
    @(negedge clk); chk("R9 window held slot D", 1, xp(1, 1, 0, 0, 0), 0);
  endtask

  task automatic t_zero;
    wr_irf(0, 0, 16'hDEAD, 16'hBEEF);
    send(pk(6'h38, 0, 0, 0, 0, 0, 1));
    chk("R5 entry 0 nop", 1, 32'h0, 1);
    @(negedge clk); chk("R5 entry 0 nop", 1, 32'h0, 1);
    @(negedge clk); chk("R5 entry 0 nop", 1, 32'h0, 1);
    @(negedge clk); chk("R5 entry 0 nop", 1, 32'h0, 1);
    @(negedge clk); chk("R5 last real", 1, xp(0, 1, 0, 0, 0), 0);
  endtask

  task automatic t_flush;
    send(pk(6'h38, 1, 2, 3, 4, 0, 5));
    chk("R10 pre-flush A", 1, xp(0, 1, 0, 0, 0), 1);
    @(negedge clk); chk("R10 pre-flush B", 1, xp(0, 2, 0, 0, 0), 1);
    flush = 1;
    @(negedge clk); flush = 0;
    chk("R10 flushed", 0, 0, 0);
    @(negedge clk); chk("R10 stays empty", 0, 0, 0);
  endtask

  task automatic t_hold;
    @(negedge clk);
    fv = 1; fw = pk(6'h3B, 1, 3, 4, 0, 0, 0);
    @(negedge clk);
    fw = 32'h8FA3_0008;
    chk("R11 A", 1, xp(0, 1, 0, 0, 0), 1);
    @(negedge clk); chk("R11 B, held word not taken", 1, xp(0, 3, 0, 0, 0), 1);
    @(negedge clk); chk("R11 C", 1, xp(0, 4, 0, 0, 0), 0);
    @(negedge clk); fv = 0;
    chk("R11 held word accepted", 1, 32'h8FA3_0008, 0);
    @(negedge clk); chk("R11 single accept", 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    wr_irf(0, 1, 16'h2465, 16'h0001);
    wr_irf(0, 2, 16'h10A0, 16'h0000);
    wr_irf(0, 3, 16'h00A4, 16'h2821);
    wr_irf(0, 4, 16'h3063, 16'h003F);
    wr_irf(0, 5, 16'h8CA6, 16'h0010);
    wr_irf(1, 1, 16'h2421, 16'h0007);
    wr_imm(3, 16'h0020);
    wr_imm(9, 16'h1234);
    t_pass();
    t_five();
    t_trim();
    t_params();
    t_window();
    t_zero();
    t_flush();
    t_hold();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule